// File: doc/BRIEF.md
# Crossed-Parity Four-Bit Read Corrector

This block protects one memory word line against single soft errors with two-dimensional even parity, and corrects four read bits in one pass. A stored line holds an N x N data matrix (64 bits by default), one parity bit per matrix row, one parity bit per matrix column, and one self-check bit over all the row and column parity bits. The write side computes the 2N+1 parity bits for a new data matrix. The line is then stored as data followed by the parity bits.

On a read, the caller presents the whole stored line together with a row index and a column index inside the upper-left quadrant. The block mirrors that position into all four quadrants and reads four bits at once. It runs four parity checks side by side: one for the selected upper row, one for the mirrored lower row, one for the selected left column and one for the mirrored right column. A bit is flipped only when both its row check and its column check fail. A failure on one axis with no failure on the other raises a parity-error flag. A mismatch of the self-check bit raises a separate flag. Results appear one clock after the read request.

Top module: `quad_parity_fix`

## Requirements
- R1: `wr_par` is the combinational even parity of `wr_data`. Bit g (g < N) is the parity of matrix row g, which holds data bits g*N to g*N+N-1. Bit N+g is the parity of column g, which holds data bits r*N+g. Bit 2N is the parity of bits 0 to 2N-1.
- R2: The stored line layout is: data bit r*N+c at line index r*N+c, row parity r at N*N+r, column parity c at N*N+N+c, and the self-check bit at N*N+2N. For `rd_row`=r and `rd_col`=c, output bit 0 reads (r,c), bit 1 reads (r,N-1-c), bit 2 reads (N-1-r,c) and bit 3 reads (N-1-r,N-1-c).
- R3: `rd_vld` equals `rd_en` delayed by one clock. All read outputs update one clock after a cycle with `rd_en` high. They hold their values after a cycle with `rd_en` low.
- R4: For a line with consistent parity, the four bits are returned unchanged, with `rd_fix`=0, `par_err`=0 and `hv_err`=0.
- R5: A single flipped data bit at one of the four read positions is corrected on output. The matching `rd_fix` bit is 1, and `par_err` and `hv_err` are 0.
- R6: A single flipped data bit that lies in exactly one of the selected rows or columns, but not at a read position, sets `par_err` and leaves the output data and `rd_fix` unchanged. A flipped data bit outside all selected rows and columns raises no flag.
- R7: A single flipped row or column parity bit sets `hv_err`. It also sets `par_err` exactly when that row or column is one of the selected ones. No data bit is modified.
- R8: A single flipped self-check bit sets `hv_err` only.
- R9: While `rst_n` is low, all outputs driven by registers are 0.
- R10: `par_err` is never 1 in a cycle where any `rd_fix` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request this cycle |
| rd_line | input | N*N+2N+1 | Stored line (data, row parity, column parity, self-check bit) |
| rd_row | input | log2(N/2) | Row index in the upper half |
| rd_col | input | log2(N/2) | Column index in the left half |
| wr_data | input | N*N | Data matrix to be written |
| wr_par | output | 2N+1 | Generated parity bits for `wr_data` |
| rd_vld | output | 1 | Read result valid |
| rd_bits | output | 4 | Corrected read bits, quadrant order per R2 |
| rd_fix | output | 4 | Per-bit correction applied |
| par_err | output | 1 | One-axis parity failure, data left unchanged |
| hv_err | output | 1 | Self-check mismatch over the parity bits |

## Verification
On every cycle the assertions check the valid timing and the hold behaviour of the output stage. They also check that each output bit equals the raw stored bit at its mirrored position, XORed with its correction flag, and that a correction never coincides with a parity-error flag. Whether a correction is actually right can only be shown by the bench scenarios. The same holds for the choice between flagging and correcting, and for whether errors in the parity bits trip the self-check. In those scenarios every single-bit error in the line is injected, including the parity and self-check bits, for every read address.

// File: rtl/quad_parity_fix.sv
module quad_parity_fix #(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [N*N+2*N:0]       rd_line,
  input  logic [$clog2(N/2)-1:0] rd_row,
  input  logic [$clog2(N/2)-1:0] rd_col,
  input  logic [N*N-1:0]         wr_data,
  output logic [2*N:0]           wr_par,
  output logic                   rd_vld,
  output logic [3:0]             rd_bits,
  output logic [3:0]             rd_fix,
  output logic                   par_err,
  output logic                   hv_err
);
  localparam int D  = N * N;
  localparam int LW = D + 2 * N + 1;
  localparam int CW = $clog2(N);

  logic [N-1:0] syn_h, syn_v, gen_h, gen_v;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [N-1:0] col_rd, col_wr;
    for (genvar r = 0; r < N; r++) begin : g_col
      assign col_rd[r] = rd_line[r*N+g];
      assign col_wr[r] = wr_data[r*N+g];
    end
    assign syn_h[g] = ^rd_line[g*N +: N] ^ rd_line[D+g];
    assign syn_v[g] = ^col_rd ^ rd_line[D+N+g];
    assign gen_h[g] = ^wr_data[g*N +: N];
    assign gen_v[g] = ^col_wr;
  end

  assign wr_par = {^{gen_v, gen_h}, gen_v, gen_h};

  logic [CW-1:0] r_up, r_dn, c_lf, c_rt;
  assign r_up = CW'(rd_row);
  assign c_lf = CW'(rd_col);
  assign r_dn = CW'(N - 1) - r_up;
  assign c_rt = CW'(N - 1) - c_lf;

  logic s_hu, s_hd, s_vl, s_vr;
  assign s_hu = syn_h[r_up];
  assign s_hd = syn_h[r_dn];
  assign s_vl = syn_v[c_lf];
  assign s_vr = syn_v[c_rt];

  logic [3:0] raw, fix;
  assign raw = {rd_line[int'(r_dn)*N + int'(c_rt)], rd_line[int'(r_dn)*N + int'(c_lf)],
                rd_line[int'(r_up)*N + int'(c_rt)], rd_line[int'(r_up)*N + int'(c_lf)]};
  assign fix = {s_hd & s_vr, s_hd & s_vl, s_hu & s_vr, s_hu & s_vl};

  logic one_axis, hv_bad;
  assign one_axis = (s_hu | s_hd) ^ (s_vl | s_vr);
  assign hv_bad   = ^rd_line[LW-1:D];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_bits <= '0;
      rd_fix  <= '0;
      par_err <= 1'b0;
      hv_err  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) begin
        rd_bits <= raw ^ fix;
        rd_fix  <= fix;
        par_err <= one_axis;
        hv_err  <= hv_bad;
      end
    end
  end
endmodule

// File: rtl/quad_parity_fix_chk.sv
module quad_parity_fix_chk #(
  parameter int N = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_en,
  input logic [N*N+2*N:0]       rd_line,
  input logic [$clog2(N/2)-1:0] rd_row,
  input logic [$clog2(N/2)-1:0] rd_col,
  input logic                   rd_vld,
  input logic [3:0]             rd_bits,
  input logic [3:0]             rd_fix,
  input logic                   par_err,
  input logic                   hv_err
);
  int ru, rd, cl, cr;
  logic [3:0] picked;
  always_comb begin
    ru = int'(rd_row);
    cl = int'(rd_col);
    rd = N - 1 - ru;
    cr = N - 1 - cl;
    picked[0] = rd_line[ru*N+cl];
    picked[1] = rd_line[ru*N+cr];
    picked[2] = rd_line[rd*N+cl];
    picked[3] = rd_line[rd*N+cr];
  end

  a_r3_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_vld == $past(rd_en));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_bits) && $stable(rd_fix) && $stable(par_err) && $stable(hv_err));

  a_r2_bits_from_line: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_bits ^ rd_fix) == $past(picked));

  a_r10_fix_excl_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fix != 4'b0) |-> !par_err);
endmodule

bind quad_parity_fix quad_parity_fix_chk #(.N(N)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_line(rd_line),
  .rd_row(rd_row), .rd_col(rd_col), .rd_vld(rd_vld), .rd_bits(rd_bits),
  .rd_fix(rd_fix), .par_err(par_err), .hv_err(hv_err)
);

// File: tb/test_quad_parity_fix.sv
module test_quad_parity_fix;
  localparam int PERIOD = 10;
  localparam int N = 8;
  localparam int D = N * N;
  localparam int LW = D + 2 * N + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0;
  logic [LW-1:0] rd_line = '0;
  logic [1:0] rd_row = '0, rd_col = '0;
  logic [D-1:0] wr_data = '0;
  logic [2*N:0] wr_par;
  logic rd_vld, par_err, hv_err;
  logic [3:0] rd_bits, rd_fix;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  quad_parity_fix #(.N(N)) i_quad_parity_fix (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_line(rd_line),
    .rd_row(rd_row), .rd_col(rd_col), .wr_data(wr_data), .wr_par(wr_par),
    .rd_vld(rd_vld), .rd_bits(rd_bits), .rd_fix(rd_fix),
    .par_err(par_err), .hv_err(hv_err)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2*N:0] ref_par(input logic [D-1:0] d);
    logic [2*N:0] p = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        p[r]   = p[r] ^ d[r*N+c];
        p[N+c] = p[N+c] ^ d[r*N+c];
      end
    for (int k = 0; k < 2*N; k++) p[2*N] = p[2*N] ^ p[k];
    return p;
  endfunction

  task automatic do_read(input logic [D-1:0] data, input int row, input int col, input int inj);
    logic [LW-1:0] clean, line;
    logic [3:0] e_bits, e_fix;
    logic e_perr, e_hv;
    int rows[2], cols[2];
    string req;
    rows[0] = row; rows[1] = N - 1 - row;
    cols[0] = col; cols[1] = N - 1 - col;
    clean = {ref_par(data), data};
    line = clean;
    if (inj >= 0) line[inj] = ~line[inj];
    for (int k = 0; k < 4; k++) e_bits[k] = clean[rows[k/2]*N + cols[k%2]];
    e_fix = '0; e_perr = 1'b0; e_hv = 1'b0;
    if (inj < 0) req = "R4";
    else if (inj < D) begin
      int er, ec;
      bit rs, cs;
      er = inj / N; ec = inj % N;
      rs = (er == rows[0]) || (er == rows[1]);
      cs = (ec == cols[0]) || (ec == cols[1]);
      if (rs && cs) begin
        req = "R5";
        e_fix[(er == rows[0] ? 0 : 2) + (ec == cols[0] ? 0 : 1)] = 1'b1;
      end else begin
        req = "R6";
        e_perr = rs ^ cs;
      end
    end else if (inj < D + N) begin
      req = "R7"; e_hv = 1'b1;
      e_perr = ((inj - D) == rows[0]) || ((inj - D) == rows[1]);
    end else if (inj < D + 2*N) begin
      req = "R7"; e_hv = 1'b1;
      e_perr = ((inj - D - N) == cols[0]) || ((inj - D - N) == cols[1]);
    end else begin
      req = "R8"; e_hv = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b1; rd_line = line; rd_row = 2'(row); rd_col = 2'(col);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R3", "rd_vld", rd_vld, 1);
    chk({req, "/R2"}, "rd_bits", rd_bits, e_bits);
    chk(req, "rd_fix", rd_fix, e_fix);
    chk(req, "par_err", par_err, e_perr);
    chk(req, "hv_err", hv_err, e_hv);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset state
    chk("R9", "rd_vld", rd_vld, 0);
    chk("R9", "rd_bits", rd_bits, 0);
    chk("R9", "rd_fix", rd_fix, 0);
    chk("R9", "flags", {par_err, hv_err}, 0);
    rst_n = 1'b1;

    // R1: generator on several patterns
    for (int t = 0; t < 20; t++) begin
      wr_data = (t == 0) ? '0 : (t == 1) ? '1 : (t == 2) ? D'(64'h1) : {$urandom, $urandom};
      #1;
      chk("R1", "wr_par", wr_par, ref_par(wr_data));
    end

    for (int a = 0; a < 16; a++) begin
      logic [D-1:0] data = {$urandom, $urandom};
      logic [3:0] keep_bits, keep_fix;
      logic keep_pe, keep_hv;
      for (int inj = -1; inj < LW; inj++) do_read(data, a / 4, a % 4, inj);
      // R3: idle cycle with a corrupted line must not disturb outputs
      keep_bits = rd_bits; keep_fix = rd_fix; keep_pe = par_err; keep_hv = hv_err;
      rd_en = 1'b0; rd_line = ~rd_line; rd_row = ~rd_row;
      @(negedge clk);
      chk("R3", "idle rd_vld", rd_vld, 0);
      chk("R3", "idle hold", {rd_bits, rd_fix, par_err, hv_err},
          {keep_bits, keep_fix, keep_pe, keep_hv});
    end

    // R10: correction and one-axis flag never together (also asserted)
    do_read(64'h0123_4567_89ab_cdef, 1, 2, 1*N+2);
    chk("R10", "fix and par_err", (rd_fix != 0) && par_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule